// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic core of a small accumulator-based controller. On every cycle it takes an operation code, the accumulator byte, a source operand byte and the carry the instruction should use. Within the same cycle it returns a result byte, the proposed new values of the carry (C), auxiliary carry (AC) and overflow (OV) flags, and one write-enable per flag that says whether the selected operation may change that flag.

A small flag register inside the block holds C, AC and OV. On a rising clock edge each flag loads its proposed value only when its own write-enable is high. Otherwise it keeps its old value. The surrounding core decides what to do with the result byte. Operand fetch, addressing and the multi-cycle multiply, divide and decimal-adjust operations sit outside this block.

Top module: `accAlu`

## Requirements
- R1: Opcode 0 (add) returns (A + S) mod 256 and writes all three flags. C is the carry out of bit 7. AC is the carry out of bit 3. OV is set when the signed sum falls outside -128..127. For example, C3h + AAh gives 6Dh with C=1, AC=0 and OV=1.
- R2: Opcode 1 (add with carry) adds carryIn as well, in the same step, and uses the flag rules of R1. For example, C3h + AAh with carryIn=1 gives 6Eh with C=1, AC=0 and OV=1.
- R3: Opcode 2 (subtract with borrow) returns (A - S - carryIn) mod 256 and writes all three flags. C is set when the unsigned difference is negative. AC is set when the low nibbles borrow, that is, when A[3:0] - S[3:0] - carryIn < 0. OV is set when the signed difference falls outside -128..127.
- R4: Opcode 3 (compare) returns A unchanged as the result. It writes only C, which is set exactly when A < S as unsigned numbers, so equal operands clear C.
- R5: Opcodes 4 (AND), 5 (OR), 6 (XOR), 7 (clear, result 00h) and 8 (one's complement of A, for example 5Ch to A3h) produce their bitwise results and raise no flag write-enable.
- R6: Opcode 9 rotates A left and opcode 11 rotates A right, with no flag writes. Opcode 10 rotates left through carry: the result is {A[6:0], carryIn} and C becomes A[7]. Opcode 12 rotates right through carry: the result is {carryIn, A[7:1]} and C becomes A[0]. Opcodes 10 and 12 write only C.
- R7: Opcode 13 (increment) and opcode 14 (decrement) wrap modulo 256, so FFh+1 gives 00h and 00h-1 gives FFh. Neither raises a flag write-enable.
- R8: Opcode 15 returns A with its high and low nibbles exchanged.
- R9: After reset the registered flags are all 0. On each rising edge a flag output takes its proposed value when its write-enable is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Operation select (encodings are given in the requirements) |
| accIn | input | 8 | Accumulator operand A |
| srcIn | input | 8 | Source operand S |
| carryIn | input | 1 | Carry used by add-with-carry, subtract and the carry rotates |
| result | output | 8 | Result byte |
| nextC | output | 1 | Proposed carry |
| nextAc | output | 1 | Proposed auxiliary carry |
| nextOv | output | 1 | Proposed overflow |
| wrC | output | 1 | Carry may be written |
| wrAc | output | 1 | Auxiliary carry may be written |
| wrOv | output | 1 | Overflow may be written |
| flagC | output | 1 | Registered carry |
| flagAc | output | 1 | Registered auxiliary carry |
| flagOv | output | 1 | Registered overflow |

## Verification
Fixed operand pairs test each flag rule on its own. Add cases that carry out of bit 3 but not bit 7, and the reverse, show whether AC and C are taken from the correct bit positions. Operand pairs of the same sign and of opposite signs show whether OV follows the signed-overflow rule rather than just copying the carry. Random operands, random carry and random opcodes drawn from all sixteen codes, each with a reference model, show whether the per-operation flag enables are right, because a flag written by mistake also changes the registered flags seen in later cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_CMP  = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_CLR  = 4'd7,
    OP_CPL  = 4'd8,  OP_RL   = 4'd9,  OP_RLC  = 4'd10, OP_RR   = 4'd11,
    OP_RRC  = 4'd12, OP_INC  = 4'd13, OP_DEC  = 4'd14, OP_SWAP = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    RS_SUM, RS_AND, RS_OR, RS_XOR, RS_ZERO, RS_INV,
    RS_ROL, RS_ROLC, RS_ROR, RS_RORC, RS_ACC, RS_SWAP
  } resSel_e;

  typedef enum logic [1:0] {
    CS_ARITH, CS_MSB, CS_LSB
  } cSrc_e;

  typedef struct packed {
    resSel_e resSel;
    logic    subMode;
    logic    srcOne;
    logic    useCarry;
    cSrc_e   cSrc;
    logic    wrC;
    logic    wrAc;
    logic    wrOv;
  } aluStrobe_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import alu8_pkg::*;
(
  input  aluOp_e     opCode,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '{resSel: RS_ACC, subMode: 1'b0, srcOne: 1'b0, useCarry: 1'b0,
               cSrc: CS_ARITH, wrC: 1'b0, wrAc: 1'b0, wrOv: 1'b0};
    case (opCode)
      OP_ADD: begin
        strobe.resSel = RS_SUM;
        strobe.wrC = 1'b1; strobe.wrAc = 1'b1; strobe.wrOv = 1'b1;
      end
      OP_ADDC: begin
        strobe.resSel = RS_SUM; strobe.useCarry = 1'b1;
        strobe.wrC = 1'b1; strobe.wrAc = 1'b1; strobe.wrOv = 1'b1;
      end
      OP_SUBB: begin
        strobe.resSel = RS_SUM; strobe.subMode = 1'b1; strobe.useCarry = 1'b1;
        strobe.wrC = 1'b1; strobe.wrAc = 1'b1; strobe.wrOv = 1'b1;
      end
      OP_CMP: begin
        strobe.resSel = RS_ACC; strobe.subMode = 1'b1;
        strobe.wrC = 1'b1;
      end
      OP_AND:  strobe.resSel = RS_AND;
      OP_OR:   strobe.resSel = RS_OR;
      OP_XOR:  strobe.resSel = RS_XOR;
      OP_CLR:  strobe.resSel = RS_ZERO;
      OP_CPL:  strobe.resSel = RS_INV;
      OP_RL:   strobe.resSel = RS_ROL;
      OP_RLC: begin
        strobe.resSel = RS_ROLC; strobe.cSrc = CS_MSB; strobe.wrC = 1'b1;
      end
      OP_RR:   strobe.resSel = RS_ROR;
      OP_RRC: begin
        strobe.resSel = RS_RORC; strobe.cSrc = CS_LSB; strobe.wrC = 1'b1;
      end
      OP_INC: begin
        strobe.resSel = RS_SUM; strobe.srcOne = 1'b1;
      end
      OP_DEC: begin
        strobe.resSel = RS_SUM; strobe.srcOne = 1'b1; strobe.subMode = 1'b1;
      end
      OP_SWAP: strobe.resSel = RS_SWAP;
      default: strobe.resSel = RS_ACC;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              nextC,
  output logic              nextAc,
  output logic              nextOv
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE_VAL = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] opBEff;
  logic              cinRaw;
  logic              cinEff;
  logic [HALF_W:0]   lowSum;
  logic [DATA_W-1:0] topLessSum;
  logic [DATA_W:0]   fullSum;
  logic              carryHalf;
  logic              carryTop;
  logic              carryOut;

  assign opB    = strobe.srcOne ? ONE_VAL : srcIn;
  assign opBEff = strobe.subMode ? ~opB : opB;
  assign cinRaw = strobe.useCarry & carryIn;
  assign cinEff = strobe.subMode ? ~cinRaw : cinRaw;

  // Three adders of growing width expose the carries at the nibble edge,
  // into the top bit and out of the top bit.
  assign lowSum     = {1'b0, accIn[HALF_W-1:0]} + {1'b0, opBEff[HALF_W-1:0]}
                    + {{HALF_W{1'b0}}, cinEff};
  assign topLessSum = {1'b0, accIn[DATA_W-2:0]} + {1'b0, opBEff[DATA_W-2:0]}
                    + {{(DATA_W-1){1'b0}}, cinEff};
  assign fullSum    = {1'b0, accIn} + {1'b0, opBEff} + {{DATA_W{1'b0}}, cinEff};

  assign carryHalf = lowSum[HALF_W];
  assign carryTop  = topLessSum[DATA_W-1];
  assign carryOut  = fullSum[DATA_W];

  // In subtract mode a missing carry means a borrow.
  assign nextAc = strobe.subMode ? ~carryHalf : carryHalf;
  assign nextOv = carryTop ^ carryOut;

  always_comb begin
    case (strobe.cSrc)
      CS_MSB:  nextC = accIn[DATA_W-1];
      CS_LSB:  nextC = accIn[0];
      default: nextC = strobe.subMode ? ~carryOut : carryOut;
    endcase
  end

  always_comb begin
    case (strobe.resSel)
      RS_SUM:  result = fullSum[DATA_W-1:0];
      RS_AND:  result = accIn & srcIn;
      RS_OR:   result = accIn | srcIn;
      RS_XOR:  result = accIn ^ srcIn;
      RS_ZERO: result = '0;
      RS_INV:  result = ~accIn;
      RS_ROL:  result = {accIn[DATA_W-2:0], accIn[DATA_W-1]};
      RS_ROLC: result = {accIn[DATA_W-2:0], carryIn};
      RS_ROR:  result = {accIn[0], accIn[DATA_W-1:1]};
      RS_RORC: result = {carryIn, accIn[DATA_W-1:1]};
      RS_SWAP: result = {accIn[HALF_W-1:0], accIn[DATA_W-1:HALF_W]};
      default: result = accIn;
    endcase
  end

endmodule

// File: rtl/accAlu.sv
module accAlu
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              nextC,
  output logic              nextAc,
  output logic              nextOv,
  output logic              wrC,
  output logic              wrAc,
  output logic              wrOv,
  output logic              flagC,
  output logic              flagAc,
  output logic              flagOv
);

  aluStrobe_t strobe;

  aluCtrl u_ctrl (
    .opCode (aluOp_e'(opCode)),
    .strobe (strobe)
  );

  aluDatapath #(.DATA_W(DATA_W)) u_dp (
    .strobe  (strobe),
    .accIn   (accIn),
    .srcIn   (srcIn),
    .carryIn (carryIn),
    .result  (result),
    .nextC   (nextC),
    .nextAc  (nextAc),
    .nextOv  (nextOv)
  );

  assign wrC  = strobe.wrC;
  assign wrAc = strobe.wrAc;
  assign wrOv = strobe.wrOv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC  <= 1'b0;
      flagAc <= 1'b0;
      flagOv <= 1'b0;
    end else begin
      if (wrC)  flagC  <= nextC;
      if (wrAc) flagAc <= nextAc;
      if (wrOv) flagOv <= nextOv;
    end
  end

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] srcIn,
  input logic              carryIn,
  input logic [DATA_W-1:0] result,
  input logic              nextC,
  input logic              nextAc,
  input logic              nextOv,
  input logic              wrC,
  input logic              wrAc,
  input logic              wrOv,
  input logic              flagC,
  input logic              flagAc,
  input logic              flagOv
);

  localparam int HALF_W = DATA_W / 2;

  // R5 R7
  no_flag_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11, 4'd13, 4'd14, 4'd15})
      |-> !(wrC || wrAc || wrOv));

  // R4
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd3) |-> (result == accIn && wrC && !wrAc && !wrOv
                          && nextC == (accIn < srcIn)));

  // R6
  rlc_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd10) |-> (wrC && nextC == accIn[DATA_W-1]
                           && result[0] == carryIn));

  // R8
  swap_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd15) |-> (result == {accIn[HALF_W-1:0], accIn[DATA_W-1:HALF_W]}));

  // R9
  carry_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrC |=> (flagC == $past(nextC)));

  // R9
  ov_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrOv |=> $stable(flagOv));

  // R1 R2 R3
  aux_implies_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAc |-> (wrC && wrOv));

endmodule

bind accAlu aluChecker #(.DATA_W(DATA_W)) u_aluChecker (.*);

// File: tb/test_accAlu.sv
module test_accAlu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] srcIn = '0;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic       nextC, nextAc, nextOv, wrC, wrAc, wrOv, flagC, flagAc, flagOv;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic mC = 1'b0, mAc = 1'b0, mOv = 1'b0;

  always #5 clk = ~clk;

  accAlu i_accAlu (
    .clk(clk), .rstN(rstN), .opCode(opCode), .accIn(accIn), .srcIn(srcIn),
    .carryIn(carryIn), .result(result), .nextC(nextC), .nextAc(nextAc),
    .nextOv(nextOv), .wrC(wrC), .wrAc(wrAc), .wrOv(wrOv), .flagC(flagC),
    .flagAc(flagAc), .flagOv(flagOv)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8: return "R5";
      4'd9, 4'd10, 4'd11, 4'd12: return "R6";
      4'd13, 4'd14: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Reference model built from the requirement text.
  task automatic refModel(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic cin, output logic [7:0] r,
                          output logic c, output logic ac, output logic ov,
                          output logic [2:0] wr);
    int s, sa, sb, lo;
    sa = a[7] ? int'(a) - 256 : int'(a);
    sb = b[7] ? int'(b) - 256 : int'(b);
    r = a; c = 1'b0; ac = 1'b0; ov = 1'b0; wr = 3'b000;
    case (op)
      4'd0, 4'd1: begin
        s = int'(a) + int'(b) + ((op == 4'd1) ? int'(cin) : 0);
        lo = int'(a[3:0]) + int'(b[3:0]) + ((op == 4'd1) ? int'(cin) : 0);
        r = s[7:0]; c = (s > 255); ac = (lo > 15);
        s = sa + sb + ((op == 4'd1) ? int'(cin) : 0);
        ov = (s > 127) || (s < -128); wr = 3'b111;
      end
      4'd2: begin
        s = int'(a) - int'(b) - int'(cin);
        lo = int'(a[3:0]) - int'(b[3:0]) - int'(cin);
        r = s[7:0]; c = (s < 0); ac = (lo < 0);
        s = sa - sb - int'(cin);
        ov = (s > 127) || (s < -128); wr = 3'b111;
      end
      4'd3: begin r = a; c = (a < b); wr = 3'b100; end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = 8'h00;
      4'd8: r = ~a;
      4'd9: r = {a[6:0], a[7]};
      4'd10: begin r = {a[6:0], cin}; c = a[7]; wr = 3'b100; end
      4'd11: r = {a[0], a[7:1]};
      4'd12: begin r = {cin, a[7:1]}; c = a[0]; wr = 3'b100; end
      4'd13: r = a + 8'd1;
      4'd14: r = a - 8'd1;
      default: r = {a[3:0], a[7:4]};
    endcase
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cin);
    logic [7:0] r;
    logic c, ac, ov;
    logic [2:0] wr;
    string req;
    req = reqOf(op);
    refModel(op, a, b, cin, r, c, ac, ov, wr);
    @(negedge clk);
    opCode = op; accIn = a; srcIn = b; carryIn = cin;
    #1;
    check(req, "result", int'(result), int'(r));
    check(req, "write enables", int'({wrC, wrAc, wrOv}), int'(wr));
    if (wr[2]) check(req, "next C", int'(nextC), int'(c));
    if (wr[1]) check(req, "next AC", int'(nextAc), int'(ac));
    if (wr[0]) check(req, "next OV", int'(nextOv), int'(ov));
    @(posedge clk);
    if (wr[2]) mC = c;
    if (wr[1]) mAc = ac;
    if (wr[0]) mOv = ov;
    #1;
    // R9: registered flags follow only enabled writes
    check("R9", "flags", int'({flagC, flagAc, flagOv}), int'({mC, mAc, mOv}));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset flags", int'({flagC, flagAc, flagOv}), 0);
    rstN = 1'b1;

    // Directed corner cases
    apply(4'd0, 8'hC3, 8'hAA, 1'b0);   // R1 example: 6D, C=1 AC=0 OV=1
    apply(4'd1, 8'hC3, 8'hAA, 1'b1);   // R2 example: 6E
    apply(4'd0, 8'h0F, 8'h01, 1'b0);   // R1 nibble carry only
    apply(4'd0, 8'h40, 8'h40, 1'b0);   // R1 positive overflow, no carry
    apply(4'd2, 8'h00, 8'h01, 1'b0);   // R3 borrow
    apply(4'd2, 8'h80, 8'h01, 1'b1);   // R3 signed overflow
    apply(4'd3, 8'h34, 8'h34, 1'b1);   // R4 equal clears C
    apply(4'd3, 8'h56, 8'h60, 1'b0);   // R4 less sets C
    apply(4'd8, 8'h5C, 8'h00, 1'b0);   // R5 5C -> A3
    apply(4'd7, 8'hFF, 8'h12, 1'b1);   // R5 clear
    apply(4'd10, 8'h81, 8'h00, 1'b0);  // R6 rotate left through carry
    apply(4'd12, 8'h01, 8'h00, 1'b1);  // R6 rotate right through carry
    apply(4'd9, 8'h81, 8'h00, 1'b0);   // R6 plain rotate
    apply(4'd13, 8'hFF, 8'h00, 1'b1);  // R7 increment wrap
    apply(4'd14, 8'h00, 8'h00, 1'b1);  // R7 decrement wrap
    apply(4'd15, 8'h3C, 8'h00, 1'b0);  // R8 swap

    // Constrained random across all opcodes
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      apply(op, 8'($urandom), 8'($urandom), 1'($urandom));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule